// File: doc/BRIEF.md
# Memory-Mapped Accelerator Command Wrapper

This block lets a host processor hand a small job to a fixed-function datapath and then forget about it until the job finishes. The host places the input words in memory. It programs the source, destination, word count, completion-flag address and an addend through a register port, then writes the start command. From then on the wrapper works alone. It reads each input word over its own memory master port, adds the addend to it in a placeholder compute stage, and writes the sum to the destination area.

When the last result has been written, the wrapper writes a flag word to the address the host chose. It then sets a sticky done bit in its status register. If the interrupt is enabled, the same done bit also drives an interrupt line. The host can therefore learn that the job is over in any of three ways: by polling memory, by polling the status register, or by taking the interrupt.

The memory master port is valid/ready. A request (read or write) is offered with `mem_req_valid` and completes in a cycle where `mem_req_ready` is also high; until then the request is held unchanged, so the memory may apply back-pressure for any number of cycles. Read data returns on a separate channel marked by `mem_rsp_valid`, and only one read is ever outstanding. The register port is a plain write strobe with combinational read data.

Top module: `accel_cmd_wrap`

## Requirements
- R1: After reset the status register (offset 0x04) reads 1: bit0 idle = 1, bit1 done = 0, bit2 error = 0. The interrupt is low and no memory request is offered.
- R2: The source (0x08), destination (0x0C), count (0x10), flag address (0x14) and addend (0x18) registers read back what was written. The control register (0x00) reads back the interrupt enable in bit1.
- R3: Writing 1 to control bit0 while idle starts a job. For i = 0 to count-1 the wrapper reads address src+4i, in increasing i, and writes (word + addend) modulo 2^32 to address dst+4i.
- R4: After the last data write, the wrapper writes the word 0x00000001 to the flag address as its final request. It then sets done and returns to idle. A new start clears done.
- R5: A memory request whose valid is high while ready is low stays valid, with address, direction and write data unchanged, in the next cycle.
- R6: At most one read is outstanding: no request is offered between a read handshake and its response.
- R7: A start written while busy is ignored and sets error. Writing 1 to status bit2 clears error.
- R8: A count of zero performs no reads and no data writes, but still writes the flag word and sets done.
- R9: The interrupt is high exactly when done is set and the interrupt enable is 1. Writing 1 to status bit1 clears done and drops the interrupt.
- R10: The job uses the register values captured at start. Writing the registers during a job does not change its addresses or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt (done AND enable) |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
Register read data is combinational, so the bench samples it in the same cycle it sets the offset, one time step after the falling edge. Status changes follow the clock edge that causes them:
- error is set in the cycle after the busy start is written;
- idle drops in the cycle after an accepted start;
- done and the interrupt rise in the cycle after the flag write handshake.

The first memory request appears one cycle after the start write. Because job length depends on memory back-pressure, the bench does not predict an exact completion cycle. Instead it polls the status register at falling edges, with a bounded wait. The memory model records every handshake, which lets the bench check address order, write count and the hold and single-outstanding rules on every cycle.

// File: rtl/acw_pkg.sv
package acw_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_STATUS = 5'h04;
  localparam logic [REG_AW-1:0] OFS_SRC    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_DST    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_COUNT  = 5'h10;
  localparam logic [REG_AW-1:0] OFS_FLAG   = 5'h14;
  localparam logic [REG_AW-1:0] OFS_ADDEND = 5'h18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WAIT, ST_WR, ST_FLAG
  } seq_state_t;
endpackage

// File: rtl/acw_regs.sv
module acw_regs import acw_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              seq_idle,
  input  logic              job_done,
  output logic              start,
  output logic [AW-1:0]     cfg_src,
  output logic [AW-1:0]     cfg_dst,
  output logic [CNT_W-1:0]  cfg_count,
  output logic [AW-1:0]     cfg_flag,
  output logic [DW-1:0]     cfg_addend,
  output logic              st_done,
  output logic              st_err,
  output logic              irq
);
  logic irq_en;
  logic go_wr, stat_wr;

  assign go_wr   = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];
  assign stat_wr = reg_wr && (reg_addr == OFS_STATUS);
  assign start   = go_wr && seq_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      cfg_src <= '0; cfg_dst <= '0; cfg_count <= '0;
      cfg_flag <= '0; cfg_addend <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL:   irq_en     <= reg_wdata[1];
        OFS_SRC:    cfg_src    <= reg_wdata[AW-1:0];
        OFS_DST:    cfg_dst    <= reg_wdata[AW-1:0];
        OFS_COUNT:  cfg_count  <= reg_wdata[CNT_W-1:0];
        OFS_FLAG:   cfg_flag   <= reg_wdata[AW-1:0];
        OFS_ADDEND: cfg_addend <= reg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  // done: set by job completion, cleared by W1C or by a new start
  always_ff @(posedge clk) begin
    if (!rst_n)                        st_done <= 1'b0;
    else if (job_done)                 st_done <= 1'b1;
    else if (start)                    st_done <= 1'b0;
    else if (stat_wr && reg_wdata[1])  st_done <= 1'b0;
  end

  // error: set by a start while busy (set wins), cleared by W1C
  always_ff @(posedge clk) begin
    if (!rst_n)                        st_err <= 1'b0;
    else if (go_wr && !seq_idle)       st_err <= 1'b1;
    else if (stat_wr && reg_wdata[2])  st_err <= 1'b0;
  end

  assign irq = st_done && irq_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:   reg_rdata[1]       = irq_en;
      OFS_STATUS: reg_rdata[2:0]     = {st_err, st_done, seq_idle};
      OFS_SRC:    reg_rdata[AW-1:0]  = cfg_src;
      OFS_DST:    reg_rdata[AW-1:0]  = cfg_dst;
      OFS_COUNT:  reg_rdata[CNT_W-1:0] = cfg_count;
      OFS_FLAG:   reg_rdata[AW-1:0]  = cfg_flag;
      OFS_ADDEND: reg_rdata[DW-1:0]  = cfg_addend;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/acw_compute.sv
module acw_compute #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] addend,
  output logic [DW-1:0] dout
);
  // placeholder transform: modular add of a host-programmed constant
  assign dout = din + addend;
endmodule

// File: rtl/acw_seq.sv
module acw_seq import acw_pkg::*; #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CNT_W     = 16,
  parameter logic [DW-1:0] FLAG_WORD = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [AW-1:0]    cfg_flag,
  input  logic [DW-1:0]    cfg_addend,
  output logic [DW-1:0]    addend_q,
  input  logic [DW-1:0]    cmp_out,
  output logic             seq_idle,
  output logic             job_done,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [DW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid
);
  localparam int WORD_SHIFT = $clog2(DW/8);

  seq_state_t      state;
  logic [AW-1:0]   src_q, dst_q, flag_q;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [DW-1:0]   res_q;
  logic [AW-1:0]   offs;
  logic            hs;

  assign offs = AW'(idx_q) << WORD_SHIFT;
  assign hs   = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      src_q <= '0; dst_q <= '0; flag_q <= '0; cnt_q <= '0;
      idx_q <= '0; res_q <= '0; addend_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          src_q <= cfg_src; dst_q <= cfg_dst; flag_q <= cfg_flag;
          cnt_q <= cfg_count; addend_q <= cfg_addend; idx_q <= '0;
          state <= (cfg_count == '0) ? ST_FLAG : ST_RD;
        end
        ST_RD:   if (hs) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          res_q <= cmp_out;
          state <= ST_WR;
        end
        ST_WR: if (hs) begin
          idx_q <= idx_q + 1'b1;
          state <= (idx_q + 1'b1 == cnt_q) ? ST_FLAG : ST_RD;
        end
        ST_FLAG: if (hs) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (state)
      ST_RD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_q + offs;
      end
      ST_WR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_q + offs;
        mem_req_wdata = res_q;
      end
      ST_FLAG: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = flag_q;
        mem_req_wdata = FLAG_WORD;
      end
      default: ;
    endcase
  end

  assign seq_idle = (state == ST_IDLE);
  assign job_done = (state == ST_FLAG) && hs;
endmodule

// File: rtl/accel_cmd_wrap.sv
module accel_cmd_wrap import acw_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data
);
  logic             start, seq_idle, job_done, st_done, st_err;
  logic [AW-1:0]    cfg_src, cfg_dst, cfg_flag;
  logic [CNT_W-1:0] cfg_count;
  logic [DW-1:0]    cfg_addend, addend_q, cmp_out;

  acw_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_idle(seq_idle),
    .job_done(job_done), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_flag(cfg_flag), .cfg_addend(cfg_addend),
    .st_done(st_done), .st_err(st_err), .irq(irq)
  );

  acw_compute #(.DW(DW)) u_cmp (
    .din(mem_rsp_data), .addend(addend_q), .dout(cmp_out)
  );

  acw_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_flag(cfg_flag),
    .cfg_addend(cfg_addend), .addend_q(addend_q), .cmp_out(cmp_out),
    .seq_idle(seq_idle), .job_done(job_done), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid)
  );
endmodule

// File: rtl/acw_checker.sv
module acw_checker import acw_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [AW-1:0]     mem_req_addr,
  input logic [DW-1:0]     mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              seq_idle,
  input logic              st_done,
  input logic              st_err
);
  logic rd_open;
  always_ff @(posedge clk) begin
    if (!rst_n)                                            rd_open <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_open <= 1'b1;
    else if (mem_rsp_valid)                                rd_open <= 1'b0;
  end

  // R5: stalled request held unchanged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata));

  // R6: nothing offered while a read is outstanding
  a_r6_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req_valid);

  // R1/R3: an idle wrapper offers no request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> !mem_req_valid);

  // R4: done only ever seen while idle
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> seq_idle);

  // R7: error rises only after a start written while busy
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> $past(reg_wr && reg_addr == OFS_CTRL && reg_wdata[0] && !seq_idle));
endmodule

bind accel_cmd_wrap acw_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid), .seq_idle(seq_idle),
  .st_done(st_done), .st_err(st_err)
);

// File: tb/accel_cmd_wrap_tb.sv
module accel_cmd_wrap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  accel_cmd_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_fail = 0;

  // ---------------- memory model ----------------
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:31];
  int          rd_n = 0, wr_n = 0;
  logic [31:0] last_wr_addr = '0;
  int          hold_viol = 0, outst_viol = 0;
  logic        stall_en = 1'b0;
  logic [7:0]  cyc = '0;
  logic        prev_stall = 1'b0, rd_open = 1'b0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  logic        prev_write = 1'b0;

  assign mem_req_ready = !stall_en || (cyc[1:0] == 2'b11);

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr &&
        mem_req_write == prev_write && mem_req_wdata == prev_wdata))
      hold_viol <= hold_viol + 1;
    prev_stall <= mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_req_addr;
    prev_write <= mem_req_write;
    prev_wdata <= mem_req_wdata;
    if (rd_open && mem_req_valid) outst_viol <= outst_viol + 1;
    if (mem_rsp_valid) rd_open <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
        wr_n <= wr_n + 1;
        last_wr_addr <= mem_req_addr;
      end else begin
        if (rd_n < 32) rd_log[rd_n] <= mem_req_addr;
        rd_n <= rd_n + 1;
        rd_open <= 1'b1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      reg_read(5'h04, s);
      if (s[1]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic setup(input logic [31:0] src, dst, n, flag, add);
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
    rd_n = 0; wr_n = 0; hold_viol = 0; outst_viol = 0;
    reg_write(5'h08, src); reg_write(5'h0C, dst); reg_write(5'h10, n);
    reg_write(5'h14, flag); reg_write(5'h18, add);
  endtask

  task automatic check_job(input string req, input logic [31:0] src, dst, n, flag, add);
    bit ok;
    wait_done(ok);
    chk(ok, {req, " done"}, 32'(ok), 1);
    chk(mem[flag[9:2]] == 32'h1, "R4 flag word", mem[flag[9:2]], 1);
    chk(last_wr_addr == flag, "R4 flag last", last_wr_addr, flag);
    chk(wr_n == n + 1, {req, " write count"}, wr_n, n + 1);
    chk(rd_n == n, {req, " read count"}, rd_n, n);
    for (int i = 0; i < n; i++) begin
      chk(rd_log[i] == src + 4*i, {req, " read order"}, rd_log[i], src + 4*i);
      chk(mem[(dst[9:2]) + i] == (32'hDEAD_0000 + src[9:2] + i) + add,
          {req, " result"}, mem[(dst[9:2]) + i], (32'hDEAD_0000 + src[9:2] + i) + add);
    end
    chk(hold_viol == 0, "R5 hold", hold_viol, 0);
    chk(outst_viol == 0, "R6 outstanding", outst_viol, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] s;
    reg_read(5'h04, s);
    chk(s == 32'h1, "R1 status", s, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(mem_req_valid == 1'b0, "R1 no request", mem_req_valid, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(5'h08, 32'h0000_1230); reg_read(5'h08, d); chk(d == 32'h1230, "R2 src", d, 32'h1230);
    reg_write(5'h0C, 32'hABCD_0000); reg_read(5'h0C, d); chk(d == 32'hABCD_0000, "R2 dst", d, 32'hABCD_0000);
    reg_write(5'h10, 32'h0000_0042); reg_read(5'h10, d); chk(d == 32'h42, "R2 count", d, 32'h42);
    reg_write(5'h14, 32'h0000_0FF0); reg_read(5'h14, d); chk(d == 32'hFF0, "R2 flag", d, 32'hFF0);
    reg_write(5'h18, 32'h8000_0001); reg_read(5'h18, d); chk(d == 32'h8000_0001, "R2 addend", d, 32'h8000_0001);
    reg_write(5'h00, 32'h2); reg_read(5'h00, d); chk(d == 32'h2, "R2 ctrl ien", d, 2);
    reg_write(5'h00, 32'h0); reg_read(5'h00, d); chk(d == 32'h0, "R2 ctrl clear", d, 0);
  endtask

  task automatic t_basic();
    stall_en = 1'b0;
    setup(32'h100, 32'h200, 6, 32'h3F0, 5);
    reg_write(5'h00, 32'h1);
    check_job("R3", 32'h100, 32'h200, 6, 32'h3F0, 5);
  endtask

  task automatic t_stall_wrap();
    logic [31:0] s;
    stall_en = 1'b1;
    setup(32'h140, 32'h240, 5, 32'h3E0, 32'hFFFF_FFFF);
    reg_write(5'h00, 32'h1);
    reg_read(5'h04, s);
    chk(s[1:0] == 2'b00, "R4 start clears done", s, 0);
    check_job("R5", 32'h140, 32'h240, 5, 32'h3E0, 32'hFFFF_FFFF);
    stall_en = 1'b0;
  endtask

  task automatic t_zero();
    setup(32'h100, 32'h200, 0, 32'h3D0, 7);
    mem[32'h200 >> 2] = 32'h5555_5555;
    reg_write(5'h00, 32'h1);
    check_job("R8", 32'h100, 32'h200, 0, 32'h3D0, 7);
    chk(mem[32'h200 >> 2] == 32'h5555_5555, "R8 dst untouched", mem[32'h200 >> 2], 32'h5555_5555);
  endtask

  task automatic t_busy();
    logic [31:0] s;
    stall_en = 1'b1;
    setup(32'h100, 32'h280, 4, 32'h3C0, 3);
    reg_write(5'h00, 32'h1);
    reg_write(5'h00, 32'h1);        // start while busy
    reg_read(5'h04, s);
    chk(s[2] == 1'b1, "R7 error set", s, 32'h4);
    reg_write(5'h08, 32'h180);      // mid-job changes must not matter
    reg_write(5'h18, 32'h99);
    check_job("R10", 32'h100, 32'h280, 4, 32'h3C0, 3);
    chk(wr_n == 5, "R7 busy start ignored", wr_n, 5);
    reg_write(5'h04, 32'h4);
    reg_read(5'h04, s);
    chk(s[2] == 1'b0, "R7 error W1C", s, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] s;
    setup(32'h100, 32'h200, 2, 32'h3B0, 1);
    reg_write(5'h00, 32'h1);        // interrupt disabled
    check_job("R9", 32'h100, 32'h200, 2, 32'h3B0, 1);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    reg_write(5'h00, 32'h2);
    #1;
    chk(irq == 1'b1, "R9 irq on enable", irq, 1);
    reg_write(5'h04, 32'h2);
    reg_read(5'h04, s);
    chk(s[1] == 1'b0, "R9 done W1C", s, 0);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);
    setup(32'h100, 32'h200, 3, 32'h3B0, 2);
    reg_write(5'h00, 32'h3);
    check_job("R9", 32'h100, 32'h200, 3, 32'h3B0, 2);
    chk(irq == 1'b1, "R9 irq enabled job", irq, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_stall_wrap();
    t_zero();
    t_busy();
    t_irq();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule